// File: doc/BRIEF.md
# Write-Back Direct-Mapped Data Cache

This block is a direct-mapped data cache placed between a single-issue CPU load/store port and a word-addressed backing memory. A CPU access is split into a tag, a line index and a word-in-block offset. Each line keeps a valid flag, a dirty flag, a stored tag and a block of several words. A hit finishes in the cycle in which it is presented. Stores that hit change only the cache and mark the line dirty.

On a miss the CPU is held off through `cpuReady`. If the line being replaced is dirty, its whole block is first copied out to memory one word per handshake. The requested block is then read in the same way. The access is then looked up again and finishes as a hit. A store that misses therefore fetches the block first and then merges its enabled bytes into it. Depending on the state of the victim, one access causes no memory burst, one burst or two bursts.

Top module: `wb_dm_cache`

## Requirements
- R1: With the default parameters, byte address bits [1:0] select the byte lane, [3:2] the word within a 4-word block, [7:4] one of 16 lines, and [31:8] form the tag. `memAddr` is a word address, equal to byte address bits [31:2].
- R2: An access hits only when the indexed line is valid and its stored tag equals the address tag. A hit raises `cpuReady` in the cycle it is presented, makes no memory request, and returns the stored word on `cpuRdata`.
- R3: A store hit writes only the byte lanes whose `cpuBe` bit is set (bit i covers data bits 8i+7..8i) and marks the line dirty. It writes nothing to memory.
- R4: A miss whose victim is invalid or clean issues exactly 4 read beats at word addresses {tag, index, 0..3} in ascending order, with no write beat.
- R5: A miss whose victim is valid and dirty first issues 4 write beats carrying the victim words to {stored tag, index, 0..3}. It then issues the 4 read beats of R4.
- R6: A store miss completes only after the refill. Its enabled bytes are merged into the fetched word, the other bytes keep the fetched value, and the line ends dirty.
- R7: `cpuReady` stays low for as long as a miss is being serviced, and is never high while `memReq` is high.
- R8: Reset clears every valid and dirty flag. Right after reset no request is pending, and each first reference to a line misses without a writeback.
- R9: While `memReq` is high and `memAck` is low, `memReq`, `memWe` and `memAddr` hold their values. Each cycle with `memAck` high moves exactly one word.
- R10: After a miss, `cpuReady` rises in the cycle that follows the clock edge consuming the last refill beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| cpuReq | input | 1 | CPU access request, held until `cpuReady` |
| cpuWe | input | 1 | 1 = store, 0 = load |
| cpuAddr | input | 32 | Byte address |
| cpuWdata | input | 32 | Store data |
| cpuBe | input | 4 | Store byte lane enables |
| cpuRdata | output | 32 | Load data, valid while `cpuReady` is high |
| cpuReady | output | 1 | Access completes at this clock edge |
| memReq | output | 1 | Memory beat request |
| memWe | output | 1 | 1 = write beat, 0 = read beat |
| memAddr | output | 30 | Memory word address |
| memWdata | output | 32 | Write beat data |
| memRdata | input | 32 | Read beat data, valid with `memAck` |
| memAck | input | 1 | Beat accepted at this clock edge |

## Verification
Directed accesses cover a cold miss, a load hit, a partial store hit, and a conflicting tag that forces a dirty eviction. They also cover a return to the evicted block, which shows that the written-back words were the merged ones, and a partial store miss. Each of these separates a different path: no burst, refill only, or writeback then refill. A long pseudo-random stream then works over four tags and four indices, with random byte enables, so that clean and dirty conflicts occur many times. The memory side acknowledges only every other cycle, which shows that the request holds its address and direction while it waits.

// File: rtl/wbc_pkg.sv
package wbc_pkg;

  typedef enum logic [1:0] {
    ST_LOOKUP = 2'd0,
    ST_WBACK  = 2'd1,
    ST_REFILL = 2'd2
  } wbcState_t;

  // Strobes from the controller to the datapath
  typedef struct packed {
    logic fillWord;   // write memRdata into the current refill beat
    logic fillDone;   // last refill beat: set valid, load tag, clear dirty
    logic storeHit;   // merge store bytes into the addressed word
    logic victimSel;  // memory address uses the stored (victim) tag
  } wbcStrobe_t;

endpackage

// File: rtl/wbc_datapath.sv
module wbc_datapath
  import wbc_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int IDX_W  = 4,
  parameter int BLK_W  = 2
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  logic [ADDR_W-$clog2(DATA_W/8)-1:0] cpuWordAddr,
  input  logic [DATA_W-1:0]                 cpuWdata,
  input  logic [DATA_W/8-1:0]               cpuBe,
  input  wbcStrobe_t                        strobe,
  input  logic [BLK_W-1:0]                  beat,
  output logic                              hit,
  output logic                              victimDirty,
  output logic [DATA_W-1:0]                 cpuRdata,
  output logic [ADDR_W-$clog2(DATA_W/8)-1:0] memAddr,
  output logic [DATA_W-1:0]                 memWdata,
  input  logic [DATA_W-1:0]                 memRdata
);

  localparam int BE_W      = DATA_W / 8;
  localparam int BOFF_W    = $clog2(BE_W);
  localparam int MADDR_W   = ADDR_W - BOFF_W;
  localparam int TAG_W     = MADDR_W - IDX_W - BLK_W;
  localparam int LINES     = 1 << IDX_W;
  localparam int WORDS_ALL = LINES << BLK_W;

  logic [TAG_W-1:0] addrTag;
  logic [IDX_W-1:0] addrIdx;
  logic [BLK_W-1:0] addrWord;

  assign addrTag  = cpuWordAddr[MADDR_W-1 -: TAG_W];
  assign addrIdx  = cpuWordAddr[BLK_W +: IDX_W];
  assign addrWord = cpuWordAddr[BLK_W-1:0];

  logic [LINES-1:0]  validArr;
  logic [LINES-1:0]  dirtyArr;
  logic [TAG_W-1:0]  tagArr  [LINES];
  logic [DATA_W-1:0] dataArr [WORDS_ALL];

  logic [IDX_W+BLK_W-1:0] cpuSlot;
  logic [IDX_W+BLK_W-1:0] beatSlot;
  assign cpuSlot  = {addrIdx, addrWord};
  assign beatSlot = {addrIdx, beat};

  // Lookup
  assign hit         = validArr[addrIdx] && (tagArr[addrIdx] == addrTag);
  assign victimDirty = validArr[addrIdx] && dirtyArr[addrIdx];
  assign cpuRdata    = dataArr[cpuSlot];
  assign memWdata    = dataArr[beatSlot];
  assign memAddr     = {(strobe.victimSel ? tagArr[addrIdx] : addrTag), addrIdx, beat};

  // Byte-lane merge of a store into the stored word
  logic [DATA_W-1:0] oldWord;
  logic [DATA_W-1:0] mergedWord;
  assign oldWord = dataArr[cpuSlot];

  genvar lane;
  generate
    for (lane = 0; lane < BE_W; lane++) begin : g_lane
      assign mergedWord[lane*8 +: 8] = cpuBe[lane] ? cpuWdata[lane*8 +: 8]
                                                   : oldWord[lane*8 +: 8];
    end
  endgenerate

  // Line state flags
  always_ff @(posedge clk) begin
    if (!rstN) begin
      validArr <= '0;
      dirtyArr <= '0;
    end else if (strobe.fillDone) begin
      validArr[addrIdx] <= 1'b1;
      dirtyArr[addrIdx] <= 1'b0;
    end else if (strobe.storeHit) begin
      dirtyArr[addrIdx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (strobe.fillDone) begin
      tagArr[addrIdx] <= addrTag;
    end
  end

  always_ff @(posedge clk) begin
    if (strobe.fillWord) begin
      dataArr[beatSlot] <= memRdata;
    end else if (strobe.storeHit) begin
      dataArr[cpuSlot] <= mergedWord;
    end
  end

  AST_STORE_MARKS_DIRTY: assert property (@(posedge clk) disable iff (!rstN)
    strobe.storeHit |=> dirtyArr[$past(addrIdx)]); // R3

  AST_FILL_LEAVES_CLEAN: assert property (@(posedge clk) disable iff (!rstN)
    strobe.fillDone |=> validArr[$past(addrIdx)] && !dirtyArr[$past(addrIdx)]
                        && (tagArr[$past(addrIdx)] == $past(addrTag))); // R4

  AST_NO_STORE_DURING_FILL: assert property (@(posedge clk) disable iff (!rstN)
    strobe.fillWord |-> !strobe.storeHit); // R7

endmodule

// File: rtl/wbc_control.sv
module wbc_control
  import wbc_pkg::*;
#(
  parameter int BLK_W = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cpuReq,
  input  logic             cpuWe,
  input  logic             hit,
  input  logic             victimDirty,
  input  logic             memAck,
  output wbcStrobe_t       strobe,
  output logic [BLK_W-1:0] beat,
  output logic             memReq,
  output logic             memWe,
  output logic             cpuReady
);

  wbcState_t state;
  logic      lastBeat;
  logic      missNow;

  assign lastBeat = &beat;
  assign missNow  = (state == ST_LOOKUP) && cpuReq && !hit;

  always_comb begin
    strobe   = '0;
    memReq   = 1'b0;
    memWe    = 1'b0;
    cpuReady = 1'b0;
    case (state)
      ST_LOOKUP: begin
        cpuReady        = cpuReq && hit;
        strobe.storeHit = cpuReq && hit && cpuWe;
      end
      ST_WBACK: begin
        memReq           = 1'b1;
        memWe            = 1'b1;
        strobe.victimSel = 1'b1;
      end
      ST_REFILL: begin
        memReq          = 1'b1;
        strobe.fillWord = memAck;
        strobe.fillDone = memAck && lastBeat;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_LOOKUP;
      beat  <= '0;
    end else begin
      case (state)
        ST_LOOKUP: begin
          if (missNow) begin
            state <= victimDirty ? ST_WBACK : ST_REFILL;
            beat  <= '0;
          end
        end
        ST_WBACK: begin
          if (memAck) begin
            beat <= beat + 1'b1;
            if (lastBeat) state <= ST_REFILL;
          end
        end
        ST_REFILL: begin
          if (memAck) begin
            beat <= beat + 1'b1;
            if (lastBeat) state <= ST_LOOKUP;
          end
        end
        default: state <= ST_LOOKUP;
      endcase
    end
  end

  AST_STALL_WHILE_MEM: assert property (@(posedge clk) disable iff (!rstN)
    memReq |-> !cpuReady); // R7

  AST_BEAT_HELD: assert property (@(posedge clk) disable iff (!rstN)
    memReq && !memAck |=> memReq && $stable(memWe) && $stable(beat)); // R9

  AST_DIRTY_GOES_OUT_FIRST: assert property (@(posedge clk) disable iff (!rstN)
    missNow && victimDirty |=> memReq && memWe); // R5

  AST_CLEAN_SKIPS_WB: assert property (@(posedge clk) disable iff (!rstN)
    missNow && !victimDirty |=> memReq && !memWe); // R4

  AST_WB_FOLLOWED_BY_FILL: assert property (@(posedge clk) disable iff (!rstN)
    $past(memReq && memWe) && !memWe |-> memReq); // R5

endmodule

// File: rtl/wb_dm_cache.sv
module wb_dm_cache
  import wbc_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int IDX_W  = 4,
  parameter int BLK_W  = 2
) (
  input  logic                               clk,
  input  logic                               rstN,
  input  logic                               cpuReq,
  input  logic                               cpuWe,
  input  logic [ADDR_W-1:0]                  cpuAddr,
  input  logic [DATA_W-1:0]                  cpuWdata,
  input  logic [DATA_W/8-1:0]                cpuBe,
  output logic [DATA_W-1:0]                  cpuRdata,
  output logic                               cpuReady,
  output logic                               memReq,
  output logic                               memWe,
  output logic [ADDR_W-$clog2(DATA_W/8)-1:0] memAddr,
  output logic [DATA_W-1:0]                  memWdata,
  input  logic [DATA_W-1:0]                  memRdata,
  input  logic                               memAck
);

  localparam int BOFF_W = $clog2(DATA_W / 8);

  wbcStrobe_t       strobe;
  logic [BLK_W-1:0] beat;
  logic             hit;
  logic             victimDirty;
  logic             unusedByteOff;

  assign unusedByteOff = ^cpuAddr[BOFF_W-1:0];

  wbc_control #(
    .BLK_W(BLK_W)
  ) i_control (
    .clk        (clk),
    .rstN       (rstN),
    .cpuReq     (cpuReq),
    .cpuWe      (cpuWe),
    .hit        (hit),
    .victimDirty(victimDirty),
    .memAck     (memAck),
    .strobe     (strobe),
    .beat       (beat),
    .memReq     (memReq),
    .memWe      (memWe),
    .cpuReady   (cpuReady)
  );

  wbc_datapath #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W),
    .IDX_W (IDX_W),
    .BLK_W (BLK_W)
  ) i_datapath (
    .clk        (clk),
    .rstN       (rstN),
    .cpuWordAddr(cpuAddr[ADDR_W-1:BOFF_W]),
    .cpuWdata   (cpuWdata),
    .cpuBe      (cpuBe),
    .strobe     (strobe),
    .beat       (beat),
    .hit        (hit),
    .victimDirty(victimDirty),
    .cpuRdata   (cpuRdata),
    .memAddr    (memAddr),
    .memWdata   (memWdata),
    .memRdata   (memRdata)
  );

endmodule

// File: tb/test_wb_dm_cache.sv
`timescale 1ns/1ps
module test_wb_dm_cache;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cpuReq = 1'b0;
  logic        cpuWe = 1'b0;
  logic [31:0] cpuAddr = '0;
  logic [31:0] cpuWdata = '0;
  logic [3:0]  cpuBe = '0;
  logic [31:0] cpuRdata;
  logic        cpuReady;
  logic        memReq;
  logic        memWe;
  logic [29:0] memAddr;
  logic [31:0] memWdata;
  logic [31:0] memRdata = '0;
  logic        memAck = 1'b0;

  always #2.5 clk = ~clk;

  wb_dm_cache i_wb_dm_cache (
    .clk(clk), .rstN(rstN), .cpuReq(cpuReq), .cpuWe(cpuWe), .cpuAddr(cpuAddr),
    .cpuWdata(cpuWdata), .cpuBe(cpuBe), .cpuRdata(cpuRdata), .cpuReady(cpuReady),
    .memReq(memReq), .memWe(memWe), .memAddr(memAddr), .memWdata(memWdata),
    .memRdata(memRdata), .memAck(memAck)
  );

  int checks = 0;
  int errors = 0;
  int cycleCnt = 0;
  bit finished = 0;

  always @(posedge clk) cycleCnt++;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  // Backing memory and the CPU's view of memory
  logic [31:0] backMem [logic [29:0]];
  logic [31:0] viewMem [logic [29:0]];

  function automatic logic [31:0] initVal(logic [29:0] w);
    return {w, 2'b01} ^ 32'hA5C3_0F1E;
  endfunction
  function automatic logic [31:0] memRd(logic [29:0] w);
    return backMem.exists(w) ? backMem[w] : initVal(w);
  endfunction
  function automatic logic [31:0] viewRd(logic [29:0] w);
    return viewMem.exists(w) ? viewMem[w] : initVal(w);
  endfunction

  // Memory responder and per-cycle port monitor
  logic [29:0] wrAddrQ[$];
  logic [31:0] wrDataQ[$];
  logic [29:0] rdAddrQ[$];
  int          lastRdCycle = 0;
  bit          ackPhase = 0;
  bit          prevPend = 0;
  logic [29:0] prevAddr = '0;
  bit          prevWe = 0;

  always @(negedge clk) begin
    bit ack;
    if (!rstN) begin
      memAck = 1'b0;
      prevPend = 0;
      ackPhase = 0;
    end else begin
      if (prevPend)
        chk(memReq && memAddr == prevAddr && memWe == prevWe, "R9",
            "beat changed before ack", {memReq, memWe, memAddr}, {1'b1, prevWe, prevAddr});
      if (memReq)
        chk(!cpuReady, "R7", "cpuReady with memReq", {31'd0, cpuReady}, 32'd0);
      ack = memReq && ackPhase;
      ackPhase = ~ackPhase;
      if (ack) begin
        if (memWe) begin
          backMem[memAddr] = memWdata;
          wrAddrQ.push_back(memAddr);
          wrDataQ.push_back(memWdata);
        end else begin
          memRdata = memRd(memAddr);
          rdAddrQ.push_back(memAddr);
          lastRdCycle = cycleCnt;
        end
      end
      memAck = ack;
      prevPend = memReq && !ack;
      prevAddr = memAddr;
      prevWe = memWe;
    end
  end

  // Behavioural reference of the cache contents
  bit          refValid [16];
  bit          refDirty [16];
  logic [23:0] refTag   [16];

  task automatic access(input bit we, input logic [31:0] addr, input logic [31:0] wd,
                        input logic [3:0] be, input string dataReq);
    logic [3:0]  idx;
    logic [23:0] tg;
    logic [29:0] w;
    bit          expHit, expWb;
    logic [29:0] expWrA [4];
    logic [31:0] expWrD [4];
    int          waited;
    int          readyCycle;
    logic [31:0] rd;
    logic [31:0] merged;
    idx = addr[7:4];
    tg  = addr[31:8];
    w   = addr[31:2];
    expHit = refValid[idx] && refTag[idx] == tg;
    expWb  = !expHit && refValid[idx] && refDirty[idx];
    for (int j = 0; j < 4; j++) begin
      expWrA[j] = {refTag[idx], idx, j[1:0]};
      expWrD[j] = viewRd(expWrA[j]);
    end
    @(negedge clk);
    cpuReq = 1'b1; cpuWe = we; cpuAddr = addr; cpuWdata = wd; cpuBe = be;
    waited = 0;
    #1;
    while (!cpuReady && waited < 200) begin
      @(negedge clk);
      #1;
      waited++;
    end
    chk(cpuReady, "R7", "access never completed", {31'd0, cpuReady}, 32'd1);
    readyCycle = cycleCnt;
    rd = cpuRdata;
    @(posedge clk);
    // Transaction shape
    chk(wrAddrQ.size() == (expWb ? 4 : 0), "R5", "write beat count", wrAddrQ.size(), expWb ? 4 : 0);
    chk(rdAddrQ.size() == (expHit ? 0 : 4), "R4", "read beat count", rdAddrQ.size(), expHit ? 0 : 4);
    if (expWb && wrAddrQ.size() == 4)
      for (int j = 0; j < 4; j++) begin
        chk(wrAddrQ[j] == expWrA[j], "R5", "writeback address", {2'b0, wrAddrQ[j]}, {2'b0, expWrA[j]});
        chk(wrDataQ[j] == expWrD[j], "R5", "writeback data", wrDataQ[j], expWrD[j]);
      end
    if (!expHit && rdAddrQ.size() == 4)
      for (int j = 0; j < 4; j++)
        chk(rdAddrQ[j] == {tg, idx, j[1:0]}, "R1", "refill address",
            {2'b0, rdAddrQ[j]}, {2'b0, tg, idx, j[1:0]});
    if (expHit)
      chk(waited == 0, "R2", "hit not ready at once", waited, 0);
    else
      chk(readyCycle == lastRdCycle + 1, "R10", "ready cycle after refill",
          readyCycle, lastRdCycle + 1);
    if (!we)
      chk(rd == viewRd(w), dataReq, "load data", rd, viewRd(w));
    // Reference update
    if (expHit) refDirty[idx] = refDirty[idx] | we;
    else        refDirty[idx] = we;
    refValid[idx] = 1;
    refTag[idx] = tg;
    if (we) begin
      merged = viewRd(w);
      for (int b = 0; b < 4; b++)
        if (be[b]) merged[b*8 +: 8] = wd[b*8 +: 8];
      viewMem[w] = merged;
    end
    wrAddrQ.delete();
    wrDataQ.delete();
    rdAddrQ.delete();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(0, "ALL", "watchdog expired", 32'd0, 32'd1);
    finishRun();
  end

  initial begin
    int unsigned seed;
    for (int i = 0; i < 16; i++) begin
      refValid[i] = 0; refDirty[i] = 0; refTag[i] = '0;
    end
    repeat (4) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    #1;
    // R8: nothing pending after reset
    chk(!cpuReady && !memReq, "R8", "reset state", {30'd0, cpuReady, memReq}, 32'd0);

    access(0, 32'h0000_0100, '0, 4'h0, "R8");            // cold miss, no writeback
    access(0, 32'h0000_0104, '0, 4'h0, "R2");            // load hit
    access(1, 32'h0000_0108, 32'h1122_3344, 4'b0011, "R3"); // partial store hit
    access(0, 32'h0000_0108, '0, 4'h0, "R3");            // merged bytes read back
    access(0, 32'h0000_0204, '0, 4'h0, "R4");            // dirty conflict: writeback + refill
    access(0, 32'h0000_0108, '0, 4'h0, "R5");            // written-back word refetched
    access(1, 32'h0000_03A4, 32'hDEAD_BEEF, 4'b1000, "R6"); // store miss
    access(0, 32'h0000_03A4, '0, 4'h0, "R6");            // merged with fetched word
    access(0, 32'h0000_0F3C, '0, 4'h0, "R1");            // highest word of line 3

    seed = 32'h1234_5678;
    for (int n = 0; n < 300; n++) begin
      logic [31:0] a;
      logic [3:0]  be;
      seed = seed * 32'd1103515245 + 32'd12345;
      a  = {22'd0, seed[17:16] + 2'd1, 2'b00, seed[21:20], seed[25:24], 2'b00};
      be = seed[11:8];
      if (be == 4'h0) be = 4'h1;
      access(seed[28], a, seed ^ 32'h5A5A_0000, be, seed[28] ? "R3" : "R2");
    end
    @(negedge clk);
    cpuReq = 1'b0;
    repeat (3) @(posedge clk);
    finishRun();
  end

endmodule